// File: doc/BRIEF.md
# Branch Target Buffer Next-PC Predictor

This block sits beside the fetch stage and guesses the address to fetch after the current one. It looks up the fetch PC in a direct-mapped table. Each entry records the word address of a taken branch or jump, that instruction's last known target, and a 2-bit saturating direction counter. A lookup that finds a matching entry whose counter leans taken returns the stored target and raises a redirect. Every other lookup returns the aligned PC plus four. No decode is needed, because an instruction that is not a branch never matches an entry.

The execute stage reports each resolved control instruction on the update port: its PC, whether it was taken, its real target, and whether the fetch-time guess was wrong. A taken instruction that is not in the table claims its slot and evicts whatever was there before. An instruction that is in the table has its counter trained by the outcome. Its target is replaced only when a misprediction is flagged and the outcome is taken.

Both the lookup (`fetch_valid`) and the update (`upd_valid`) carry a valid qualifier and have no ready. The block accepts one lookup and one update in every cycle, so it never applies back-pressure. The lookup path is combinational. An update is written at the next rising clock edge.

Top module: `btb_predictor`

## Requirements
- R1: The table has 2^IDX_W entries, indexed by PC bits [IDX_W+1:2]. A lookup hits only when the entry is valid and its stored word address (PC bits [PC_W-1:2]) equals the fetch word address.
- R2: PC bits [1:0] are ignored. The sequential next PC is {pc[PC_W-1:2],2'b00} + 4, and a lookup with nonzero low bits hits the same entry.
- R3: On a miss, or when fetch_valid is low, pred_hit, pred_taken and redirect are 0 and pred_next_pc is the sequential next PC.
- R4: On a hit, the counter encoding is 0 strong not-taken, 1 weak not-taken, 2 weak taken, 3 strong taken, and counter bit 1 is the prediction. When that bit is set, pred_taken and redirect are 1 and pred_next_pc is the stored target (low two bits zero). Otherwise pred_hit is 1, redirect is 0, and pred_next_pc is the sequential PC.
- R5: A resolved taken instruction that misses the table is allocated with its PC and target and a counter of 2 (weak taken).
- R6: A resolved not-taken instruction that misses the table allocates nothing.
- R7: A resolved taken instruction that hits with upd_mispredict set has its stored target replaced by upd_target.
- R8: A resolve that hits with upd_mispredict clear leaves the target unchanged and only trains the counter.
- R9: On a hit, the counter counts up on taken and down on not-taken, saturating at 3 and 0.
- R10: When a lookup and an update address the same entry in one cycle, the lookup sees the old contents and the update is visible from the next cycle.
- R11: A taken instruction whose index matches a valid entry with a different tag replaces that entry.
- R12: Synchronous reset clears every valid bit, so the first lookup after reset misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_valid | input | 1 | Fetch PC is valid |
| fetch_pc | input | PC_W | Current fetch PC |
| pred_next_pc | output | PC_W | Predicted next fetch PC |
| pred_hit | output | 1 | Lookup matched a valid entry |
| pred_taken | output | 1 | Matching entry predicts taken |
| redirect | output | 1 | Fetch should go to the stored target |
| upd_valid | input | 1 | A control instruction resolved |
| upd_pc | input | PC_W | PC of the resolved instruction |
| upd_taken | input | 1 | Actual direction |
| upd_target | input | PC_W | Actual target |
| upd_mispredict | input | 1 | Fetch-time guess was wrong |

## Verification
A lookup and an update can land on the same entry in the same cycle. The bench provokes this by driving the fetch PC and a taken, allocating update for that same PC in one cycle. It judges the result by requiring a miss with the sequential PC in that cycle, then a taken hit with the new target in the next one. Index aliasing and counter saturation are each walked step by step, and the outputs are checked after every step.

// File: rtl/btb_pkg.sv
package btb_pkg;
  typedef enum logic [1:0] {
    CTR_STRONG_NT = 2'd0,
    CTR_WEAK_NT   = 2'd1,
    CTR_WEAK_T    = 2'd2,
    CTR_STRONG_T  = 2'd3
  } ctr_e;

  localparam ctr_e CTR_ALLOC = CTR_WEAK_T;

  function automatic ctr_e ctr_train(input ctr_e cur, input logic taken);
    ctr_e res;
    res = cur;
    if (taken) begin
      if (cur != CTR_STRONG_T) res = ctr_e'(cur + 2'd1);
    end else begin
      if (cur != CTR_STRONG_NT) res = ctr_e'(cur - 2'd1);
    end
    return res;
  endfunction

  function automatic logic ctr_says_taken(input ctr_e cur);
    return cur[1];
  endfunction
endpackage

// File: rtl/btb_index.sv
module btb_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4,
  localparam int WORD_W = PC_W - 2
) (
  input  logic [PC_W-1:0]   pc,
  output logic [WORD_W-1:0] word,
  output logic [IDX_W-1:0]  idx,
  output logic [PC_W-1:0]   seq_pc
);
  logic unused_lsb;
  assign unused_lsb = ^pc[1:0];
  assign word   = pc[PC_W-1:2];
  assign idx    = pc[IDX_W+1:2];
  assign seq_pc = {pc[PC_W-1:2] + WORD_W'(1), 2'b00};
endmodule

// File: rtl/btb_table.sv
module btb_table
  import btb_pkg::*;
#(
  parameter int WORD_W = 30,
  parameter int IDX_W  = 4,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  fa_idx,
  output logic              fa_valid,
  output logic [WORD_W-1:0] fa_tag,
  output logic [WORD_W-1:0] fa_tgt,
  output ctr_e              fa_ctr,
  input  logic [IDX_W-1:0]  ua_idx,
  output logic              ua_valid,
  output logic [WORD_W-1:0] ua_tag,
  output logic [WORD_W-1:0] ua_tgt,
  output ctr_e              ua_ctr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_tag,
  input  logic [WORD_W-1:0] wr_tgt,
  input  ctr_e              wr_ctr
);
  logic [DEPTH-1:0]  ent_valid;
  logic [WORD_W-1:0] ent_tag [DEPTH];
  logic [WORD_W-1:0] ent_tgt [DEPTH];
  ctr_e              ent_ctr [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic hit_wr;
    assign hit_wr = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_valid[e] <= 1'b0;
      end else if (hit_wr) begin
        ent_valid[e] <= 1'b1;
      end
    end
    always_ff @(posedge clk) begin
      if (hit_wr) begin
        ent_tag[e] <= wr_tag;
        ent_tgt[e] <= wr_tgt;
        ent_ctr[e] <= wr_ctr;
      end
    end
  end

  always_comb begin
    fa_valid = ent_valid[fa_idx];
    fa_tag   = ent_tag[fa_idx];
    fa_tgt   = ent_tgt[fa_idx];
    fa_ctr   = ent_ctr[fa_idx];
    ua_valid = ent_valid[ua_idx];
    ua_tag   = ent_tag[ua_idx];
    ua_tgt   = ent_tgt[ua_idx];
    ua_ctr   = ent_ctr[ua_idx];
  end
endmodule

// File: rtl/btb_lookup.sv
module btb_lookup
  import btb_pkg::*;
#(
  parameter int PC_W = 32,
  localparam int WORD_W = PC_W - 2
) (
  input  logic              req,
  input  logic [WORD_W-1:0] word,
  input  logic [PC_W-1:0]   seq_pc,
  input  logic              ent_valid,
  input  logic [WORD_W-1:0] ent_tag,
  input  logic [WORD_W-1:0] ent_tgt,
  input  ctr_e              ent_ctr,
  output logic [PC_W-1:0]   next_pc,
  output logic              hit,
  output logic              taken,
  output logic              redir
);
  always_comb begin
    hit     = req && ent_valid && (ent_tag == word);
    taken   = hit && ctr_says_taken(ent_ctr);
    redir   = taken;
    next_pc = taken ? {ent_tgt, 2'b00} : seq_pc;
  end
endmodule

// File: rtl/btb_update_ctl.sv
module btb_update_ctl
  import btb_pkg::*;
#(
  parameter int WORD_W = 30
) (
  input  logic              upd_valid,
  input  logic [WORD_W-1:0] upd_word,
  input  logic              upd_taken,
  input  logic              upd_mispredict,
  input  logic [WORD_W-1:0] upd_tgt_word,
  input  logic              ent_valid,
  input  logic [WORD_W-1:0] ent_tag,
  input  logic [WORD_W-1:0] ent_tgt,
  input  ctr_e              ent_ctr,
  output logic              wr_en,
  output logic [WORD_W-1:0] wr_tag,
  output logic [WORD_W-1:0] wr_tgt,
  output ctr_e              wr_ctr
);
  logic present;

  always_comb begin
    present = ent_valid && (ent_tag == upd_word);
    wr_en   = upd_valid && (present || upd_taken);
    wr_tag  = upd_word;
    if (present) begin
      wr_ctr = ctr_train(ent_ctr, upd_taken);
      wr_tgt = (upd_mispredict && upd_taken) ? upd_tgt_word : ent_tgt;
    end else begin
      wr_ctr = CTR_ALLOC;
      wr_tgt = upd_tgt_word;
    end
  end
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int PC_W  = 32,
  parameter int IDX_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fetch_valid,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] pred_next_pc,
  output logic            pred_hit,
  output logic            pred_taken,
  output logic            redirect,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [PC_W-1:0] upd_target,
  input  logic            upd_mispredict
);
  localparam int WORD_W = PC_W - 2;

  logic [WORD_W-1:0] f_word, u_word, t_word;
  logic [IDX_W-1:0]  f_idx, u_idx, t_idx_unused;
  logic [PC_W-1:0]   f_seq, u_seq_unused, t_seq_unused;

  btb_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_fidx (
    .pc(fetch_pc), .word(f_word), .idx(f_idx), .seq_pc(f_seq));
  btb_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_uidx (
    .pc(upd_pc), .word(u_word), .idx(u_idx), .seq_pc(u_seq_unused));
  btb_index #(.PC_W(PC_W), .IDX_W(IDX_W)) u_tidx (
    .pc(upd_target), .word(t_word), .idx(t_idx_unused), .seq_pc(t_seq_unused));

  logic              fa_valid, ua_valid, wr_en;
  logic [WORD_W-1:0] fa_tag, fa_tgt, ua_tag, ua_tgt, wr_tag, wr_tgt;
  ctr_e              fa_ctr, ua_ctr, wr_ctr;

  btb_table #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_table (
    .clk(clk), .rst(rst),
    .fa_idx(f_idx), .fa_valid(fa_valid), .fa_tag(fa_tag), .fa_tgt(fa_tgt), .fa_ctr(fa_ctr),
    .ua_idx(u_idx), .ua_valid(ua_valid), .ua_tag(ua_tag), .ua_tgt(ua_tgt), .ua_ctr(ua_ctr),
    .wr_en(wr_en), .wr_idx(u_idx), .wr_tag(wr_tag), .wr_tgt(wr_tgt), .wr_ctr(wr_ctr));

  btb_lookup #(.PC_W(PC_W)) u_lookup (
    .req(fetch_valid), .word(f_word), .seq_pc(f_seq),
    .ent_valid(fa_valid), .ent_tag(fa_tag), .ent_tgt(fa_tgt), .ent_ctr(fa_ctr),
    .next_pc(pred_next_pc), .hit(pred_hit), .taken(pred_taken), .redir(redirect));

  btb_update_ctl #(.WORD_W(WORD_W)) u_upd (
    .upd_valid(upd_valid), .upd_word(u_word), .upd_taken(upd_taken),
    .upd_mispredict(upd_mispredict), .upd_tgt_word(t_word),
    .ent_valid(ua_valid), .ent_tag(ua_tag), .ent_tgt(ua_tgt), .ent_ctr(ua_ctr),
    .wr_en(wr_en), .wr_tag(wr_tag), .wr_tgt(wr_tgt), .wr_ctr(wr_ctr));
endmodule

// File: rtl/btb_checker.sv
module btb_checker #(
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            fetch_valid,
  input logic [PC_W-1:0] fetch_pc,
  input logic [PC_W-1:0] pred_next_pc,
  input logic            pred_hit,
  input logic            pred_taken,
  input logic            redirect
);
  logic [PC_W-1:0] exp_seq;
  logic            rst_seen;
  assign exp_seq = {fetch_pc[PC_W-1:2], 2'b00} + PC_W'(4);

  always_ff @(posedge clk) rst_seen <= rst;

  assert_miss_seq_R3: assert property (@(posedge clk) disable iff (rst)
    !pred_hit |-> (pred_next_pc == exp_seq && !redirect && !pred_taken));
  assert_idle_miss_R3: assert property (@(posedge clk) disable iff (rst)
    !fetch_valid |-> !pred_hit);
  assert_taken_redirect_R4: assert property (@(posedge clk) disable iff (rst)
    (pred_hit && pred_taken) |-> redirect);
  assert_nt_hit_seq_R4: assert property (@(posedge clk) disable iff (rst)
    (pred_hit && !pred_taken) |-> (pred_next_pc == exp_seq && !redirect));
  assert_target_aligned_R4: assert property (@(posedge clk) disable iff (rst)
    redirect |-> (pred_hit && pred_next_pc[1:0] == 2'b00));
  assert_reset_clears_R12: assert property (@(posedge clk) disable iff (rst)
    rst_seen |-> !pred_hit);
endmodule

bind btb_predictor btb_checker #(.PC_W(PC_W)) u_btb_checker (
  .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
  .pred_next_pc(pred_next_pc), .pred_hit(pred_hit), .pred_taken(pred_taken),
  .redirect(redirect));

// File: tb/btb_predictor_bench.sv
module btb_predictor_bench;
  localparam int PC_W = 32;
  logic clk = 1'b0, rst = 1'b1;
  logic fetch_valid = 1'b0, upd_valid = 1'b0, upd_taken = 1'b0, upd_mispredict = 1'b0;
  logic [PC_W-1:0] fetch_pc = '0, upd_pc = '0, upd_target = '0;
  logic [PC_W-1:0] pred_next_pc;
  logic pred_hit, pred_taken, redirect;
  int n_chk = 0, n_fail = 0;

  always #10 clk = ~clk;

  btb_predictor #(.PC_W(PC_W), .IDX_W(4)) u_btb_predictor (
    .clk(clk), .rst(rst), .fetch_valid(fetch_valid), .fetch_pc(fetch_pc),
    .pred_next_pc(pred_next_pc), .pred_hit(pred_hit), .pred_taken(pred_taken),
    .redirect(redirect), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_target(upd_target), .upd_mispredict(upd_mispredict));

  task automatic chk(input string req, input logic [PC_W-1:0] act, input logic [PC_W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic look(input string req, input logic [PC_W-1:0] pc,
                      input logic hit, input logic tk, input logic [PC_W-1:0] nxt);
    fetch_valid = 1'b1;
    fetch_pc = pc;
    #1;
    chk({req, " hit"}, PC_W'(pred_hit), PC_W'(hit));
    chk({req, " taken"}, PC_W'(pred_taken), PC_W'(tk));
    chk({req, " redirect"}, PC_W'(redirect), PC_W'(tk));
    chk({req, " next"}, pred_next_pc, nxt);
  endtask

  task automatic resolve(input logic [PC_W-1:0] pc, input logic tk,
                         input logic [PC_W-1:0] tgt, input logic mp);
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = pc; upd_taken = tk; upd_target = tgt; upd_mispredict = mp;
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    look("R12 after reset", 32'h1000, 1'b0, 1'b0, 32'h1004);
    look("R3 miss", 32'h2224, 1'b0, 1'b0, 32'h2228);
    fetch_valid = 1'b0;
    #1 chk("R3 idle no hit", PC_W'(pred_hit), '0);
  endtask

  task automatic t_alloc();
    resolve(32'h1000, 1'b0, 32'h9000, 1'b1);
    look("R6 not-taken not allocated", 32'h1000, 1'b0, 1'b0, 32'h1004);
    resolve(32'h1000, 1'b1, 32'h8000, 1'b1);
    look("R5 allocated weak taken", 32'h1000, 1'b1, 1'b1, 32'h8000);
    look("R1 other index misses", 32'h1004, 1'b0, 1'b0, 32'h1008);
    look("R2 low bits ignored", 32'h1003, 1'b1, 1'b1, 32'h8000);
    resolve(32'h1000, 1'b0, 32'h8000, 1'b1);
    look("R5 weak taken drops to not-taken", 32'h1000, 1'b1, 1'b0, 32'h1004);
  endtask

  task automatic t_counter();
    resolve(32'h2008, 1'b1, 32'h3000, 1'b1);
    resolve(32'h2008, 1'b1, 32'h3000, 1'b0);
    resolve(32'h2008, 1'b1, 32'h3000, 1'b0);
    resolve(32'h2008, 1'b0, 32'h3000, 1'b1);
    look("R9 saturated then one down", 32'h2008, 1'b1, 1'b1, 32'h3000);
    resolve(32'h2008, 1'b0, 32'h3000, 1'b1);
    look("R4 hit not-taken gives seq", 32'h200A, 1'b1, 1'b0, 32'h200C);
    resolve(32'h2008, 1'b0, 32'h3000, 1'b0);
    resolve(32'h2008, 1'b0, 32'h3000, 1'b0);
    resolve(32'h2008, 1'b1, 32'h3000, 1'b1);
    look("R9 saturated at zero", 32'h2008, 1'b1, 1'b0, 32'h200C);
    resolve(32'h2008, 1'b1, 32'h3000, 1'b1);
    look("R9 back to weak taken", 32'h2008, 1'b1, 1'b1, 32'h3000);
  endtask

  task automatic t_target();
    resolve(32'h2008, 1'b1, 32'h4000, 1'b0);
    look("R8 target kept without mispredict", 32'h2008, 1'b1, 1'b1, 32'h3000);
    resolve(32'h2008, 1'b1, 32'h5002, 1'b1);
    look("R7 target rewritten", 32'h2008, 1'b1, 1'b1, 32'h5000);
  endtask

  task automatic t_alias();
    resolve(32'h1040, 1'b0, 32'h7000, 1'b1);
    look("R6 alias not-taken keeps old", 32'h1000, 1'b1, 1'b0, 32'h1004);
    resolve(32'h1040, 1'b1, 32'h7000, 1'b1);
    look("R11 alias replaces entry", 32'h1040, 1'b1, 1'b1, 32'h7000);
    look("R11 old owner now misses", 32'h1000, 1'b0, 1'b0, 32'h1004);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    upd_valid = 1'b1; upd_pc = 32'h2030; upd_taken = 1'b1;
    upd_target = 32'h6600; upd_mispredict = 1'b1;
    look("R10 same cycle sees old", 32'h2030, 1'b0, 1'b0, 32'h2034);
    @(negedge clk);
    upd_valid = 1'b0;
    look("R10 next cycle sees new", 32'h2030, 1'b1, 1'b1, 32'h6600);
  endtask

  task automatic t_reset_clear();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    look("R12 reset clears", 32'h2008, 1'b0, 1'b0, 32'h200C);
    look("R12 reset clears alias", 32'h1040, 1'b0, 1'b0, 32'h1044);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_alloc();
    t_counter();
    t_target();
    t_alias();
    t_same_cycle();
    t_reset_clear();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule